// File: doc/BRIEF.md
# Multiplexed-Address DRAM Emulator

This block stands in for a 4-bit-wide asynchronous dynamic memory so that a memory controller can be checked against a live target. The controller drives active-low row strobe, column strobe, write strobe and output enable, plus a shared 10-bit address bus and a 4-bit data input. The emulator samples these on a fast system clock and treats every strobe change as synchronous to it. It latches a row on the row-strobe fall. The column latch is transparent while the column strobe is high, so read data flows through from the live address. The latch freezes when the column strobe falls.

The storage array is small and set by parameters. Address bits above the row and column widths are dropped, so high addresses alias onto the small array. A column-strobe fall with W low is an early write: the sampled data is stored and the output stays disabled for the rest of that column cycle. Several column cycles may run under one row-strobe low period (page mode). A column-strobe fall while the row strobe is high performs no access and sets a sticky error flag.

Top module: `dram_emu`

## Requirements
- R1: After reset `dout_en` and `err_o` are 0 and every cell reads 0.
- R2: The row index is taken from the low ROW_BITS of `addr` in the clock where `ras_n` is first seen low. Address changes later in that row-strobe period do not change the row.
- R3: While `ras_n` is low and `cas_n` is high, `dout` shows the cell at the latched row and the column on the live `addr`, in the same clock.
- R4: Once `cas_n` has fallen, the column stays frozen until `cas_n` rises, even if `addr` changes.
- R5: `we_n` low in the clock where `cas_n` falls (with `ras_n` low since an earlier clock) stores `din` into the addressed cell. `dout_en` then stays 0 for the whole column cycle, whatever `oe_n` and `we_n` do.
- R6: `dout_en` is 1 only when `ras_n`, `cas_n` and `oe_n` are all low in a read cycle. It drops in the same clock that `cas_n` or `oe_n` goes high.
- R7: Read data equals the data last written to that cell, bit for bit, with the same polarity.
- R8: Several column cycles under one `ras_n` low period access different columns of the same row, for reads and for writes.
- R9: `din` has no effect during a read cycle.
- R10: Address bits above ROW_BITS (row phase) and COL_BITS (column phase) are ignored.
- R11: A `cas_n` fall while `ras_n` is high stores nothing and enables no output. It sets `err_o` from the next clock, and `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, all strobes sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write select, low selects write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data (valid when dout_en is 1) |
| dout_en | output | 1 | Output driver enable (low means high impedance) |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
The output enable and read data are combinational from the strobes and the latched state, so they are due in the same clock as the strobe change that causes them. The bench changes inputs on the falling clock edge and samples 1 ns later, before the next rising edge. A write lands in the array on the rising edge that samples the column-strobe fall, and the error flag is set on that same edge. Both are checked one clock later, and stored data is checked by a later read cycle.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

    localparam int ADDR_W = 10;
    localparam int DQ_W   = 4;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
    } strobe_ev_t;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    function automatic cyc_e cycle_kind(input logic we_n);
        return we_n ? CYC_READ : CYC_WRITE;
    endfunction

endpackage

// File: rtl/dram_emu_strobes.sv
module dram_emu_strobes
    import dram_emu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ras_n,
    input  logic       cas_n,
    output logic       ras_q,
    output logic       cas_q,
    output strobe_ev_t ev
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    always_comb begin
        ev.ras_fall = ras_q & ~ras_n;
        ev.ras_rise = ~ras_q & ras_n;
        ev.cas_fall = cas_q & ~cas_n;
        ev.cas_rise = ~cas_q & cas_n;
    end

endmodule

// File: rtl/dram_emu_addr.sv
module dram_emu_addr
    import dram_emu_pkg::*;
#(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ras_fall,
    input  logic                ras_n,
    input  logic                cas_q,
    input  logic [ADDR_W-1:0]   addr,
    output logic [ROW_BITS-1:0] row_q,
    output logic [COL_BITS-1:0] col_q,
    output logic [COL_BITS-1:0] col_eff
);

    localparam int HI_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

    logic [ROW_BITS-1:0] row_in;
    logic [COL_BITS-1:0] col_in;
    logic                unused_hi;

    assign row_in    = addr[ROW_BITS-1:0];
    assign col_in    = addr[COL_BITS-1:0];
    assign unused_hi = ^addr[ADDR_W-1:HI_W];

    // Row: captured once per row-strobe period.
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (ras_fall) begin
            row_q <= row_in;
        end
    end

    // Column: follows the bus while the column strobe was high, so the
    // value present at the fall is the one kept.
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
        end else if (!ras_n && cas_q) begin
            col_q <= col_in;
        end
    end

    assign col_eff = cas_q ? col_in : col_q;

endmodule

// File: rtl/dram_emu_array.sv
module dram_emu_array
    import dram_emu_pkg::*;
#(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  logic [DQ_W-1:0]     wr_data,
    output logic [DQ_W-1:0]     rd_data
);

    localparam int IDX_W = ROW_BITS + COL_BITS;
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] idx;
    logic [DQ_W-1:0]  words [DEPTH];

    assign idx = {row, col};

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[w] <= '0;
            end else if (wr_en && (idx == IDX_W'(w))) begin
                words[w] <= wr_data;
            end
        end
    end

    assign rd_data = words[idx];

endmodule

// File: rtl/dram_emu_ctrl.sv
module dram_emu_ctrl
    import dram_emu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  strobe_ev_t ev,
    input  logic       ras_n,
    input  logic       ras_q,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       oe_n,
    output logic       wr_en,
    output logic       dout_en,
    output logic       err_o
);

    cyc_e cyc_q;
    cyc_e cyc_now;
    logic access;
    logic stray_cas;

    // An access needs the row strobe low in this and the previous sample.
    assign access    = ev.cas_fall && !ras_n && !ras_q;
    assign stray_cas = ev.cas_fall && ras_n;
    assign cyc_now   = access ? cycle_kind(we_n) : cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= CYC_IDLE;
        end else if (access) begin
            cyc_q <= cycle_kind(we_n);
        end else if (ev.cas_rise || ev.ras_rise || ev.ras_fall || stray_cas) begin
            cyc_q <= CYC_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o <= 1'b0;
        end else if (stray_cas) begin
            err_o <= 1'b1;
        end
    end

    assign wr_en   = access && !we_n;
    assign dout_en = !ras_n && !cas_n && !oe_n && (cyc_now == CYC_READ);

endmodule

// File: rtl/dram_emu.sv
module dram_emu
    import dram_emu_pkg::*;
#(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   din,
    output logic [DQ_W-1:0]   dout,
    output logic              dout_en,
    output logic              err_o
);

    strobe_ev_t          ev;
    logic                ras_q;
    logic                cas_q;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic [COL_BITS-1:0] col_eff;
    logic                wr_en;

    dram_emu_strobes u_strobes (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .ras_q (ras_q),
        .cas_q (cas_q),
        .ev    (ev)
    );

    dram_emu_addr #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .ras_fall (ev.ras_fall),
        .ras_n    (ras_n),
        .cas_q    (cas_q),
        .addr     (addr),
        .row_q    (row_q),
        .col_q    (col_q),
        .col_eff  (col_eff)
    );

    dram_emu_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .ras_n   (ras_n),
        .ras_q   (ras_q),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .wr_en   (wr_en),
        .dout_en (dout_en),
        .err_o   (err_o)
    );

    dram_emu_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .row     (row_q),
        .col     (col_eff),
        .wr_data (din),
        .rd_data (dout)
    );

endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk #(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                ras_n,
    input logic                cas_n,
    input logic                we_n,
    input logic                oe_n,
    input logic                dout_en,
    input logic                err_o,
    input logic [ROW_BITS-1:0] row_q,
    input logic [COL_BITS-1:0] col_q
);

    logic cas_d;
    logic early_q;
    logic early_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cas_d   <= 1'b1;
            early_q <= 1'b0;
        end else begin
            cas_d <= cas_n;
            if (cas_n) early_q <= 1'b0;
            else if (early_now) early_q <= 1'b1;
        end
    end

    assign early_now = early_q || (cas_d && !cas_n && !ras_n && !we_n);

    p_out_gate_r6: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (!ras_n && !cas_n && !oe_n));

    p_early_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        early_now |-> !dout_en);

    p_err_sets_r11: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && ras_n) |=> err_o);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_row_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && $past(!ras_n)) |=> $stable(row_q));

    p_col_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !cas_n && $past(!cas_n)) |=> $stable(col_q));

endmodule

bind dram_emu dram_emu_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dout_en (dout_en),
    .err_o   (err_o),
    .row_q   (row_q),
    .col_q   (col_q)
);

// File: tb/sim_dram_emu.sv
`timescale 1ns/1ps
module sim_dram_emu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [9:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_en, err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dram_emu u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .err_o(err_o)
    );

    // {write, row[2:0], col[2:0], value[3:0]}; for reads value is expected data
    localparam logic [10:0] VEC [12] = '{
        {1'b1, 3'd2, 3'd1, 4'h5}, {1'b1, 3'd2, 3'd4, 4'hC}, {1'b1, 3'd2, 3'd7, 4'h3},
        {1'b1, 3'd5, 3'd0, 4'hA}, {1'b1, 3'd5, 3'd3, 4'h6}, {1'b1, 3'd3, 3'd0, 4'hE},
        {1'b0, 3'd2, 3'd1, 4'h5}, {1'b0, 3'd2, 3'd7, 4'h3}, {1'b0, 3'd2, 3'd4, 4'hC},
        {1'b0, 3'd5, 3'd3, 4'h6}, {1'b0, 3'd5, 3'd0, 4'hA}, {1'b0, 3'd3, 3'd0, 4'hE}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic ras_open(input logic [9:0] a);
        @(negedge clk); addr = a; ras_n = 1'b0;
    endtask

    task automatic ras_close();
        @(negedge clk); ras_n = 1'b1;
    endtask

    // One column cycle: address set with CAS high, then CAS and OE low.
    task automatic cas_cycle(input logic [9:0] a, input logic wr, input logic [3:0] d,
                             output logic [3:0] q, output logic en);
        @(negedge clk); addr = a; we_n = ~wr; din = d;
        @(negedge clk); cas_n = 1'b0; oe_n = 1'b0;
        #1; q = dout; en = dout_en;
        @(negedge clk); cas_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] q;
        logic       en;
        logic [2:0] cur_row;
        logic       open;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 dout_en after reset", dout_en, 0);
        chk("R1 err_o after reset", err_o, 0);
        chk("R1 cell 0 after reset", dout, 0);

        // Table walk: page mode within a row, new RAS period on row change
        open = 1'b0; cur_row = '0;
        for (int i = 0; i < 12; i++) begin
            logic       w;
            logic [2:0] r, c;
            logic [3:0] v;
            {w, r, c, v} = VEC[i];
            if (!open || r != cur_row) begin
                if (open) ras_close();
                ras_open({7'd0, r});
                open = 1'b1; cur_row = r;
            end
            cas_cycle({7'd0, c}, w, w ? v : ~v, q, en);
            if (w) begin
                chk("R5 write cycle output disabled", en, 0);
            end else begin
                chk("R7 R8 page read data", q, v);
                chk("R6 read output enabled", en, 1);
            end
        end
        ras_close();

        // R9: din driven during a read must leave the cell intact
        ras_open(10'd5);
        cas_cycle(10'd0, 1'b0, 4'h1, q, en);
        cas_cycle(10'd0, 1'b0, 4'h7, q, en);
        chk("R9 cell unchanged by din on read", q, 4'hA);
        ras_close();

        // R2: column phase address 0 must not re-select row 0
        ras_open(10'd3);
        cas_cycle(10'd0, 1'b0, 4'h0, q, en);
        chk("R2 row kept from RAS fall", q, 4'hE);
        ras_close();

        // R5: early write with OE low and W released mid cycle
        ras_open(10'd1);
        @(negedge clk); addr = 10'd2; we_n = 1'b0; din = 4'h7;
        @(negedge clk); cas_n = 1'b0; oe_n = 1'b0;
        #1; chk("R5 early write output off", dout_en, 0);
        @(negedge clk); we_n = 1'b1;
        #1; chk("R5 output off after W high", dout_en, 0);
        @(negedge clk); cas_n = 1'b1; oe_n = 1'b1;
        cas_cycle(10'd2, 1'b0, 4'h0, q, en);
        chk("R5 R7 early write stored", q, 4'h7);
        ras_close();

        // R6, R4, R3 within one row period on row 2
        ras_open(10'd2);
        @(negedge clk); addr = 10'd4; we_n = 1'b1;
        @(negedge clk); cas_n = 1'b0; oe_n = 1'b0;
        #1; chk("R6 enable with all low", dout_en, 1);
        chk("R6 read data", dout, 4'hC);
        @(negedge clk); addr = 10'd7;
        #1; chk("R4 column frozen", dout, 4'hC);
        @(negedge clk); oe_n = 1'b1;
        #1; chk("R6 OE high drops enable", dout_en, 0);
        @(negedge clk); oe_n = 1'b0;
        #1; chk("R6 OE low re-enables", dout_en, 1);
        @(negedge clk); cas_n = 1'b1;
        #1; chk("R6 CAS high drops enable", dout_en, 0);
        @(negedge clk); addr = 10'd1;
        #1; chk("R3 flow-through col 1", dout, 4'h5);
        @(negedge clk); addr = 10'd7;
        #1; chk("R3 flow-through col 7", dout, 4'h3);
        oe_n = 1'b1;
        ras_close();

        // R10: high address bits alias onto the small array
        ras_open(10'h3FA);
        cas_cycle(10'h2C1, 1'b1, 4'h9, q, en);
        ras_close();
        ras_open(10'd2);
        cas_cycle(10'd1, 1'b0, 4'h0, q, en);
        chk("R10 aliased write visible", q, 4'h9);
        ras_close();

        // R11: CAS fall with RAS high, last row was 2, column bus 4
        @(negedge clk); addr = 10'd4; we_n = 1'b0; din = 4'hF;
        @(negedge clk); cas_n = 1'b0; oe_n = 1'b0;
        #1; chk("R11 no output on stray CAS", dout_en, 0);
        @(negedge clk); cas_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        #1; chk("R11 err set", err_o, 1);
        ras_open(10'd2);
        cas_cycle(10'd4, 1'b0, 4'h0, q, en);
        chk("R11 no write on stray CAS", q, 4'hC);
        chk("R11 err sticky", err_o, 1);
        ras_close();

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1; chk("R1 err cleared by reset", err_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule